// File: doc/BRIEF.md
# Dual-Bank Barrel Shifter with High/Low Reference

The block places a 16-bit operand anywhere in a 32-bit result field in one clock cycle. A signed 8-bit code sets how far the operand moves, and a reference select sets where code zero puts it. A positive code moves the operand left and a negative code moves it right. The code is taken from the exponent register, from its two's-complement negation, or from an immediate operand. A 32-bit value can therefore be shifted one half at a time with the same code, once against the high reference and once against the low reference.

Output bits below the placed operand are zero. Output bits above it take an extension bit, which is the operand MSB, an external carry flag, or zero. The new shift output either replaces the result register or is ORed into it, which gives double-precision shifts.

The block holds four registers: the shift input, an 8-bit exponent, a 5-bit block exponent and the 32-bit result. There are two banks of these registers, and a bank select bit picks one of them. Reads take the value stored at the start of a cycle and writes land at its end. One register can therefore supply an operand and take a new value in the same cycle.

Top module: `dual_bank_shifter`

## Requirements
- R1: The operand is placed with its bit 0 at position p. p is the signed code, plus 16 when `hi_ref_i` is 1. Output bits below p are zero. The operand comes from the shift input register, or from `ext_data_i` when `ext_sel_i` is 1.
- R2: Output bits above the placed operand take an extension bit. `fill_src_i` selects it: 0 gives the operand MSB, 1 gives `carry_i`, and 2 or 3 give zero.
- R3: `code_src_i` selects the code. 0 gives the exponent register and 1 gives its negation in 8 bits, wrapping, so -(-128) = -128. 2 or 3 give `imm_code_i`.
- R4: When p >= 32, the output is all zero. When p <= -16, every output bit equals the extension bit.
- R5: When `or_merge_i` is 1, a shift stores the shift output ORed with the previous result. Otherwise the shift output replaces the result.
- R6: `se_o` is the 8-bit exponent register sign-extended to 16 bits. `sb_o` is the 5-bit block exponent sign-extended to 16 bits. Each loads from the low bits of `wr_data_i`.
- R7: `wr_sr0_i` loads bits 15:0 of the result and `wr_sr1_i` loads bits 31:16, both from `wr_data_i`. A direct load of a half overrides a shift result for that half in the same cycle.
- R8: `bank_sel_i` = 0 selects the primary bank and 1 selects the alternate bank, for reads, writes and shifts alike. The other bank keeps its contents.
- R9: A shift reads the register values from before the clock edge. A load of the shift input in the same cycle takes effect only for later shifts. Results appear on `sr_o` one cycle after the shift.
- R10: Reset clears every register in both banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_sel_i | input | 1 | Register bank select |
| wr_data_i | input | 16 | Load data for all registers |
| wr_si_i | input | 1 | Load shift input register |
| wr_se_i | input | 1 | Load exponent register |
| wr_sb_i | input | 1 | Load block exponent register |
| wr_sr0_i | input | 1 | Load result bits 15:0 |
| wr_sr1_i | input | 1 | Load result bits 31:16 |
| shift_en_i | input | 1 | Perform a shift into the result |
| ext_sel_i | input | 1 | Take operand from ext_data_i |
| ext_data_i | input | 16 | External operand |
| code_src_i | input | 2 | Code source select |
| imm_code_i | input | 8 | Immediate signed code |
| hi_ref_i | input | 1 | High reference select |
| fill_src_i | input | 2 | Extension bit source select |
| carry_i | input | 1 | External carry flag |
| or_merge_i | input | 1 | OR shift output into previous result |
| si_o | output | 16 | Shift input register, active bank |
| se_o | output | 16 | Exponent, sign-extended, active bank |
| sb_o | output | 16 | Block exponent, sign-extended, active bank |
| sr_o | output | 32 | Result register, active bank |

## Verification
A wrong placement offset or reference shows at `sr_o` one cycle after the shift. Shifting against both references with codes near the edges exposes it at once. A corrupt bank-select path stays hidden until the other bank is read back, so the bench switches banks and checks that the idle bank kept its values. An error in the merge path shows only in bits that were already set. Merges are therefore checked on a result that has content in both halves.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [1:0] {
    CODE_EXP = 2'd0,
    CODE_NEG = 2'd1,
    CODE_IMM = 2'd2
  } code_src_e;

  typedef enum logic [1:0] {
    FILL_MSB   = 2'd0,
    FILL_CARRY = 2'd1,
    FILL_ZERO  = 2'd2
  } fill_src_e;
endpackage

// File: rtl/bshift_ctrl.sv
module bshift_ctrl #(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] exp_i,
  input  logic [CODE_W-1:0] imm_i,
  input  logic [1:0]        code_src_i,
  input  logic [1:0]        fill_src_i,
  input  logic              opnd_msb_i,
  input  logic              carry_i,
  output logic [CODE_W-1:0] code_o,
  output logic              fill_o
);
  import bshift_pkg::*;

  always_comb begin
    unique case (code_src_i)
      CODE_EXP: code_o = exp_i;
      CODE_NEG: code_o = ~exp_i + 1'b1;
      default:  code_o = imm_i;
    endcase
  end

  always_comb begin
    unique case (fill_src_i)
      FILL_MSB:   fill_o = opnd_msb_i;
      FILL_CARRY: fill_o = carry_i;
      default:    fill_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bshift_array.sv
module bshift_array #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 8
) (
  input  logic [DATA_W-1:0]   opnd_i,
  input  logic [CODE_W-1:0]   code_i,
  input  logic                hi_ref_i,
  input  logic                fill_i,
  output logic [2*DATA_W-1:0] out_o
);
  localparam int OUT_W = 2 * DATA_W;
  localparam int EXT_W = OUT_W + DATA_W;
  localparam int POS_W = CODE_W + 2;

  logic signed [POS_W-1:0] pos;
  logic        [POS_W-1:0] amt;
  logic        [EXT_W-1:0] ext;
  logic        [EXT_W-1:0] moved;

  // signed placement of operand bit 0
  assign pos = POS_W'($signed(code_i)) + (hi_ref_i ? POS_W'(DATA_W) : POS_W'(0));
  assign ext = {{OUT_W{fill_i}}, opnd_i};
  assign amt = pos[POS_W-1] ? POS_W'(-pos) : POS_W'(pos);

  always_comb begin
    moved = '0;
    if (!pos[POS_W-1]) begin
      if (amt < POS_W'(OUT_W)) moved = ext << amt;
    end else if (amt < POS_W'(DATA_W)) begin
      moved = ext >> amt;
    end else begin
      moved = {EXT_W{fill_i}};
    end
  end

  assign out_o = moved[OUT_W-1:0];
endmodule

// File: rtl/bshift_bank.sv
module bshift_bank #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 8,
  parameter int BLK_W  = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                act_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                wr_si_i,
  input  logic                wr_se_i,
  input  logic                wr_sb_i,
  input  logic                wr_sr0_i,
  input  logic                wr_sr1_i,
  input  logic                shift_en_i,
  input  logic [2*DATA_W-1:0] res_i,
  output logic [DATA_W-1:0]   si_o,
  output logic [CODE_W-1:0]   se_o,
  output logic [BLK_W-1:0]    sb_o,
  output logic [2*DATA_W-1:0] sr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      si_o <= '0;
      se_o <= '0;
      sb_o <= '0;
      sr_o <= '0;
    end else if (act_i) begin
      if (wr_si_i) si_o <= wr_data_i;
      if (wr_se_i) se_o <= wr_data_i[CODE_W-1:0];
      if (wr_sb_i) sb_o <= wr_data_i[BLK_W-1:0];
      // direct half loads win over the shift result
      if (wr_sr0_i)        sr_o[DATA_W-1:0] <= wr_data_i;
      else if (shift_en_i) sr_o[DATA_W-1:0] <= res_i[DATA_W-1:0];
      if (wr_sr1_i)        sr_o[2*DATA_W-1:DATA_W] <= wr_data_i;
      else if (shift_en_i) sr_o[2*DATA_W-1:DATA_W] <= res_i[2*DATA_W-1:DATA_W];
    end
  end
endmodule

// File: rtl/dual_bank_shifter.sv
module dual_bank_shifter #(
  parameter int DATA_W    = 16,
  parameter int CODE_W    = 8,
  parameter int BLK_W     = 5,
  parameter int NUM_BANKS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bank_sel_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                wr_si_i,
  input  logic                wr_se_i,
  input  logic                wr_sb_i,
  input  logic                wr_sr0_i,
  input  logic                wr_sr1_i,
  input  logic                shift_en_i,
  input  logic                ext_sel_i,
  input  logic [DATA_W-1:0]   ext_data_i,
  input  logic [1:0]          code_src_i,
  input  logic [CODE_W-1:0]   imm_code_i,
  input  logic                hi_ref_i,
  input  logic [1:0]          fill_src_i,
  input  logic                carry_i,
  input  logic                or_merge_i,
  output logic [DATA_W-1:0]   si_o,
  output logic [DATA_W-1:0]   se_o,
  output logic [DATA_W-1:0]   sb_o,
  output logic [2*DATA_W-1:0] sr_o
);
  import bshift_pkg::*;

  localparam int OUT_W = 2 * DATA_W;

  logic [DATA_W-1:0] si_b [NUM_BANKS];
  logic [CODE_W-1:0] se_b [NUM_BANKS];
  logic [BLK_W-1:0]  sb_b [NUM_BANKS];
  logic [OUT_W-1:0]  sr_b [NUM_BANKS];

  logic [DATA_W-1:0] si_cur;
  logic [CODE_W-1:0] se_cur;
  logic [BLK_W-1:0]  sb_cur;
  logic [OUT_W-1:0]  sr_cur;
  logic [DATA_W-1:0] opnd;
  logic [CODE_W-1:0] code;
  logic              fill;
  logic [OUT_W-1:0]  shift_out;
  logic [OUT_W-1:0]  res;

  assign si_cur = si_b[bank_sel_i];
  assign se_cur = se_b[bank_sel_i];
  assign sb_cur = sb_b[bank_sel_i];
  assign sr_cur = sr_b[bank_sel_i];

  assign opnd = ext_sel_i ? ext_data_i : si_cur;

  bshift_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .exp_i      (se_cur),
    .imm_i      (imm_code_i),
    .code_src_i (code_src_i),
    .fill_src_i (fill_src_i),
    .opnd_msb_i (opnd[DATA_W-1]),
    .carry_i    (carry_i),
    .code_o     (code),
    .fill_o     (fill)
  );

  bshift_array #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_array (
    .opnd_i   (opnd),
    .code_i   (code),
    .hi_ref_i (hi_ref_i),
    .fill_i   (fill),
    .out_o    (shift_out)
  );

  assign res = or_merge_i ? (shift_out | sr_cur) : shift_out;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bshift_bank #(.DATA_W(DATA_W), .CODE_W(CODE_W), .BLK_W(BLK_W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .act_i      (bank_sel_i == 1'(g)),
      .wr_data_i  (wr_data_i),
      .wr_si_i    (wr_si_i),
      .wr_se_i    (wr_se_i),
      .wr_sb_i    (wr_sb_i),
      .wr_sr0_i   (wr_sr0_i),
      .wr_sr1_i   (wr_sr1_i),
      .shift_en_i (shift_en_i),
      .res_i      (res),
      .si_o       (si_b[g]),
      .se_o       (se_b[g]),
      .sb_o       (sb_b[g]),
      .sr_o       (sr_b[g])
    );
  end

  assign si_o = si_cur;
  assign se_o = {{(DATA_W-CODE_W){se_cur[CODE_W-1]}}, se_cur};
  assign sb_o = {{(DATA_W-BLK_W){sb_cur[BLK_W-1]}}, sb_cur};
  assign sr_o = sr_cur;

  assert_left_offscale_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_src_i == CODE_IMM && hi_ref_i && !imm_code_i[CODE_W-1] &&
     int'(imm_code_i) >= DATA_W) |-> (shift_out == '0));

  assert_right_offscale_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_src_i == CODE_IMM && !hi_ref_i && int'($signed(imm_code_i)) <= -DATA_W)
    |-> (shift_out == '0 || shift_out == '1));

  assert_merge_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_i && or_merge_i && !wr_sr0_i && !wr_sr1_i)
    |=> (bank_sel_i != $past(bank_sel_i)) || ((sr_o & $past(sr_o)) == $past(sr_o)));

  assert_sr0_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sr0_i |=> (bank_sel_i != $past(bank_sel_i)) ||
                 (sr_o[DATA_W-1:0] == $past(wr_data_i)));

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_en_i && !wr_sr0_i && !wr_sr1_i && !wr_si_i)
    |=> (bank_sel_i != $past(bank_sel_i)) || ($stable(sr_o) && $stable(si_o)));
endmodule

// File: tb/dual_bank_shifter_tb_top.sv
`timescale 1ns/1ps
module dual_bank_shifter_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bank_sel, wr_si, wr_se, wr_sb, wr_sr0, wr_sr1, shift_en, ext_sel;
  logic        hi_ref, carry, or_merge;
  logic [15:0] wr_data, ext_data;
  logic [1:0]  code_src, fill_src;
  logic [7:0]  imm_code;
  logic [15:0] si_o, se_o, sb_o;
  logic [31:0] sr_o;

  logic [15:0] m_si [2];
  logic [7:0]  m_se [2];
  logic [4:0]  m_sb [2];
  logic [31:0] m_sr [2];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_bank_shifter dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bank_sel_i(bank_sel), .wr_data_i(wr_data),
    .wr_si_i(wr_si), .wr_se_i(wr_se), .wr_sb_i(wr_sb), .wr_sr0_i(wr_sr0),
    .wr_sr1_i(wr_sr1), .shift_en_i(shift_en), .ext_sel_i(ext_sel),
    .ext_data_i(ext_data), .code_src_i(code_src), .imm_code_i(imm_code),
    .hi_ref_i(hi_ref), .fill_src_i(fill_src), .carry_i(carry),
    .or_merge_i(or_merge), .si_o(si_o), .se_o(se_o), .sb_o(sb_o), .sr_o(sr_o)
  );

  function automatic logic [31:0] ref_shift(logic [15:0] x, logic [7:0] c,
                                            logic hi, logic f);
    int p = int'($signed(c)) + (hi ? 16 : 0);
    logic [31:0] r;
    for (int j = 0; j < 32; j++) begin
      int k = j - p;
      if (k < 0)       r[j] = 1'b0;
      else if (k > 15) r[j] = f;
      else             r[j] = x[k];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int b = int'(bank_sel);
    chk({tag, " si"}, 32'(si_o), 32'(m_si[b]));
    chk({tag, " se"}, 32'(se_o), 32'({{8{m_se[b][7]}}, m_se[b]}));
    chk({tag, " sb"}, 32'(sb_o), 32'({{11{m_sb[b][4]}}, m_sb[b]}));
    chk({tag, " sr"}, sr_o, m_sr[b]);
  endtask

  task automatic step(string tag);
    int b = int'(bank_sel);
    logic [15:0] op;
    logic [7:0]  c;
    logic        f;
    logic [31:0] sh, nr;
    op = ext_sel ? ext_data : m_si[b];
    c  = (code_src == 2'd0) ? m_se[b] : (code_src == 2'd1) ? 8'(-m_se[b]) : imm_code;
    f  = (fill_src == 2'd0) ? op[15] : (fill_src == 2'd1) ? carry : 1'b0;
    sh = ref_shift(op, c, hi_ref, f);
    nr = m_sr[b];
    if (shift_en) nr = or_merge ? (sh | m_sr[b]) : sh;
    if (wr_sr0) nr[15:0]  = wr_data;
    if (wr_sr1) nr[31:16] = wr_data;
    @(posedge clk);
    @(negedge clk);
    if (wr_si) m_si[b] = wr_data;
    if (wr_se) m_se[b] = wr_data[7:0];
    if (wr_sb) m_sb[b] = wr_data[4:0];
    m_sr[b] = nr;
    compare(tag);
    {wr_si, wr_se, wr_sb, wr_sr0, wr_sr1, shift_en, or_merge} = '0;
  endtask

  task automatic do_shift(logic [1:0] src, logic [7:0] imm, logic hi,
                          logic [1:0] fs, string tag);
    code_src = src; imm_code = imm; hi_ref = hi; fill_src = fs; shift_en = 1'b1;
    step(tag);
  endtask

  task automatic do_load(logic [15:0] d, logic [4:0] which, string tag);
    wr_data = d;
    {wr_si, wr_se, wr_sb, wr_sr0, wr_sr1} = which;
    step(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed = 32'd7;
    void'($urandom(seed));
    {bank_sel, wr_si, wr_se, wr_sb, wr_sr0, wr_sr1, shift_en, ext_sel} = '0;
    {hi_ref, carry, or_merge} = '0;
    wr_data = '0; ext_data = '0; code_src = 2'd2; fill_src = '0; imm_code = '0;
    for (int i = 0; i < 2; i++) begin
      m_si[i] = '0; m_se[i] = '0; m_sb[i] = '0; m_sr[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R10 reset bank0");
    bank_sel = 1'b1; #1;
    compare("R10 reset bank1");
    bank_sel = 1'b0;

    // R1 placement against both references
    do_load(16'h1234, 5'b10000, "R9 load si");
    do_shift(2'd2, 8'd0,   1'b1, 2'd2, "R1 hi code 0");
    do_shift(2'd2, 8'd0,   1'b0, 2'd2, "R1 lo code 0");
    do_shift(2'd2, 8'd4,   1'b0, 2'd2, "R1 lo code 4");
    do_shift(2'd2, 8'hFD,  1'b1, 2'd2, "R1 hi code -3");
    ext_sel = 1'b1; ext_data = 16'hC3A5;
    do_shift(2'd2, 8'd9,   1'b0, 2'd0, "R1 external operand");
    ext_sel = 1'b0;

    // R2 extension bit sources
    do_load(16'h8001, 5'b10000, "R9 load si");
    do_shift(2'd2, 8'hFC, 1'b0, 2'd0, "R2 fill msb");
    carry = 1'b1;
    do_shift(2'd2, 8'hFC, 1'b0, 2'd1, "R2 fill carry 1");
    carry = 1'b0;
    do_shift(2'd2, 8'hFC, 1'b0, 2'd1, "R2 fill carry 0");
    do_shift(2'd2, 8'hFC, 1'b0, 2'd2, "R2 fill zero");
    do_shift(2'd2, 8'h05, 1'b0, 2'd3, "R2 fill code 3");

    // R3 code sources, R6 readback
    do_load(16'h0003, 5'b01000, "R6 load se 3");
    do_shift(2'd0, 8'h00, 1'b0, 2'd0, "R3 code exp");
    do_shift(2'd1, 8'h00, 1'b1, 2'd0, "R3 code neg exp");
    do_load(16'h0080, 5'b01000, "R6 se sign ext");
    do_shift(2'd1, 8'h00, 1'b1, 2'd0, "R3 neg of -128");
    do_shift(2'd3, 8'h02, 1'b0, 2'd0, "R3 code src 3 imm");
    do_load(16'h0010, 5'b00100, "R6 sb negative");
    do_load(16'hFF0F, 5'b00100, "R6 sb positive");

    // R4 off-scale
    do_shift(2'd2, 8'd16,  1'b1, 2'd0, "R4 left off hi");
    do_shift(2'd2, 8'd127, 1'b0, 2'd0, "R4 left off lo 127");
    do_shift(2'd2, 8'hF0,  1'b0, 2'd0, "R4 right off lo -16");
    carry = 1'b1;
    do_shift(2'd2, 8'h80,  1'b1, 2'd1, "R4 right off hi -128");
    carry = 1'b0;
    do_shift(2'd2, 8'd15,  1'b1, 2'd0, "R4 edge hi 15");

    // R5 OR merge for double precision
    do_load(16'hA5F0, 5'b10000, "R9 load si");
    do_shift(2'd2, 8'hFC, 1'b0, 2'd2, "R5 low half plain");
    do_load(16'h0F0F, 5'b10000, "R9 load si");
    or_merge = 1'b1;
    do_shift(2'd2, 8'hFC, 1'b1, 2'd2, "R5 high half merged");

    // R7 half loads
    do_load(16'hAAAA, 5'b00010, "R7 load low half");
    do_load(16'h5555, 5'b00001, "R7 load high half");
    wr_data = 16'h1357; wr_sr1 = 1'b1;
    do_shift(2'd2, 8'd0, 1'b0, 2'd2, "R7 load beats shift");

    // R8 bank isolation
    bank_sel = 1'b1;
    do_load(16'hBEEF, 5'b10000, "R8 bank1 load");
    do_shift(2'd2, 8'd2, 1'b1, 2'd0, "R8 bank1 shift");
    bank_sel = 1'b0; #1;
    compare("R8 bank0 kept");
    bank_sel = 1'b1; #1;
    compare("R8 bank1 kept");
    bank_sel = 1'b0;

    // R9 same-cycle read and write
    wr_data = 16'h00FF; wr_si = 1'b1;
    do_shift(2'd2, 8'd0, 1'b0, 2'd2, "R9 shift uses old si");
    do_shift(2'd2, 8'd0, 1'b0, 2'd2, "R9 new si visible");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      bank_sel = 1'($urandom_range(0, 1));
      wr_data  = 16'($urandom());
      ext_data = 16'($urandom());
      wr_si    = ($urandom_range(0, 3) == 0);
      wr_se    = ($urandom_range(0, 5) == 0);
      wr_sb    = ($urandom_range(0, 5) == 0);
      wr_sr0   = ($urandom_range(0, 7) == 0);
      wr_sr1   = ($urandom_range(0, 7) == 0);
      shift_en = ($urandom_range(0, 1) == 1);
      ext_sel  = ($urandom_range(0, 3) == 0);
      or_merge = ($urandom_range(0, 2) == 0);
      hi_ref   = 1'($urandom_range(0, 1));
      carry    = 1'($urandom_range(0, 1));
      code_src = 2'($urandom_range(0, 3));
      fill_src = 2'($urandom_range(0, 3));
      imm_code = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 40) - 20)
                                             : 8'($urandom());
      step("R1_R2_R3_R5_R8 random");
    end

    finish_run();
  end
endmodule